// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block fills host-provided receive buffers from a byte stream. The host builds a circular list of descriptors in a word-addressed memory. Each descriptor is four consecutive 32-bit words: a status word at offset 0, a buffer word address at offset 1, a buffer capacity at offset 2 and the address of the next descriptor at offset 3. The host loads the first descriptor address and then issues a start command. The engine reads the descriptor at its current address. If the engine owns that descriptor, it streams the incoming frame into the buffer as packed 32-bit words. At the end of the frame it writes the received length and a status word without the ownership bit, pulses a done flag, follows the next pointer and fetches again. If it reaches a descriptor that the host still owns, it stops, raises `ring_empty` and stays idle until the next start command. It does not poll.

The byte input is a valid/ready stream. A byte moves on a rising edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is high only while the engine has an owned buffer open, so the source must hold `rx_data`, `rx_last` and `rx_err` steady while `rx_valid` is high and `rx_ready` is low. Gaps in `rx_valid` are allowed. The memory port has one-cycle latency: a read issued on one edge returns data on `mem_rdata` for the following cycle. A write takes effect on the edge where it is issued.

Top module: `rxr_engine`

## Requirements
- R1: While reset is held and right after it, `busy`, `ring_empty`, `frame_done`, `rx_ready` and `mem_req` are low.
- R2: A `start` while idle makes the engine read the descriptor at the current address. `base_load` while idle sets that address from `base_addr`.
- R3: If status bit 31 (ownership, 1 = engine owns) of the fetched descriptor is 0, the engine goes idle with `ring_empty` high and writes nothing. It issues no further reads until the next `start`, which fetches only that status word again.
- R4: Frame byte k is stored in buffer word `buffer + k/4`, at bits `8*(k%4)+7 : 8*(k%4)` (little-endian packing).
- R5: When the frame ends partway through a word, that last word is written with its unused upper byte lanes set to zero. Words after it are not touched.
- R6: After the frame, descriptor word 2 holds the number of bytes stored, zero-extended.
- R7: After the frame, descriptor word 0 is written as: bit 31 = 0, bit 13 = giant flag, bits 2:1 = `rx_err` as sampled with the last byte, all other bits 0.
- R8: A frame longer than the capacity (low LEN_W bits of word 2 as fetched) is a giant frame. Bytes past the capacity are dropped, memory past the capacity is untouched, the stored length equals the capacity, and bit 13 is set.
- R9: `frame_done` is high for exactly one cycle, the cycle after the status write.
- R10: After a frame the engine continues at the descriptor named in word 3. It wraps around the ring and stops at the first descriptor the host owns.
- R11: `rx_ready` is high only while busy with an owned buffer open, never while the engine reads descriptors. Bytes move only on valid-and-ready cycles, so idle gaps in `rx_valid` do not change the stored data.
- R12: `start` and `base_load` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_load | input | 1 | Load descriptor address (idle only) |
| base_addr | input | ADDR_W | Descriptor word address to load |
| start | input | 1 | Start/resume fetching (idle only) |
| rx_valid | input | 1 | Byte stream valid |
| rx_ready | output | 1 | Byte stream ready |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks last byte of the frame |
| rx_err | input | 2 | Frame error code, sampled with the last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |
| busy | output | 1 | Engine not idle |
| ring_empty | output | 1 | Stopped at a host-owned descriptor |
| frame_done | output | 1 | One-cycle pulse after the status write |

## Verification
The bench builds the engine with ADDR_W = 8 and the default LEN_W = 16. With these values a 256-word array models the whole address space, so every write the engine makes, including a stray one, lands in memory the bench can inspect. Capacities are read from the descriptors, so small values such as 6 and 64 exercise giant frames, partial last words and writes just below the capacity within a few dozen cycles. Counting reads in the memory model shows that the engine does not poll a host-owned descriptor.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W    = 32;
  localparam int OWN_BIT   = 31;
  localparam int GIANT_BIT = 13;
  localparam int ERR_LSB   = 1;
  localparam int DESC_LEN_OFS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RECV,
    ST_FLUSH,
    ST_WBLEN,
    ST_WBST
  } rxr_state_e;
endpackage

// File: rtl/rxr_pack.sv
module rxr_pack #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat,
  input  logic [7:0]       data,
  input  logic [LEN_W-1:0] cap,
  input  logic             flush_ack,
  output logic             pend,
  output logic [31:0]      full_word,
  output logic [LEN_W-3:0] full_ofs,
  output logic             part_any,
  output logic [31:0]      part_word,
  output logic [LEN_W-3:0] part_ofs,
  output logic [LEN_W-1:0] count,
  output logic             giant
);
  localparam int OFS_W = LEN_W - 2;

  logic [31:0]      lanes;
  logic             flushed;
  logic [OFS_W-1:0] cnt_word;

  assign cnt_word  = count[LEN_W-1:2];
  assign part_any  = (count[1:0] != 2'd0) && !flushed;
  assign part_word = lanes;
  assign part_ofs  = cnt_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes     <= '0;
      count     <= '0;
      giant     <= 1'b0;
      flushed   <= 1'b0;
      pend      <= 1'b0;
      full_word <= '0;
      full_ofs  <= '0;
    end else begin
      pend <= 1'b0;
      if (clear) begin
        lanes   <= '0;
        count   <= '0;
        giant   <= 1'b0;
        flushed <= 1'b0;
      end else if (beat) begin
        if (count < cap) begin
          if (count[1:0] == 2'd3) begin
            full_word <= {data, lanes[23:0]};
            full_ofs  <= cnt_word;
            pend      <= 1'b1;
            lanes     <= '0;
          end else begin
            lanes[{count[1:0], 3'b000} +: 8] <= data;
          end
          count <= count + 1'b1;
        end else begin
          giant <= 1'b1;
        end
      end
      if (flush_ack) flushed <= 1'b1;
    end
  end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              start,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [1:0]        rx_err,
  output logic              rx_ready,
  output logic              beat,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              ring_empty,
  output logic              frame_done,
  output logic              pk_clear,
  output logic              pk_flush_ack,
  output logic [LEN_W-1:0]  cap,
  input  logic              pk_pend,
  input  logic [31:0]       pk_full_word,
  input  logic [LEN_W-3:0]  pk_full_ofs,
  input  logic              pk_part_any,
  input  logic [31:0]       pk_part_word,
  input  logic [LEN_W-3:0]  pk_part_ofs,
  input  logic [LEN_W-1:0]  pk_count,
  input  logic              pk_giant
);
  rxr_state_e        state;
  logic [1:0]        fidx;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] buf_base;
  logic [ADDR_W-1:0] nxt;
  logic [1:0]        err_q;
  logic [WORD_W-1:0] st_word;
  logic              unused_rdata;

  assign unused_rdata = ^mem_rdata;
  assign busy         = (state != ST_IDLE);
  assign rx_ready     = (state == ST_RECV);
  assign beat         = rx_valid && rx_ready;
  assign pk_clear     = (state == ST_WAIT) && (fidx == 2'd3);
  assign pk_flush_ack = (state == ST_FLUSH) && !pk_pend && pk_part_any;

  always_comb begin
    st_word                = '0;
    st_word[GIANT_BIT]     = pk_giant;
    st_word[ERR_LSB +: 2]  = err_q;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (pk_pend) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = buf_base + ADDR_W'(pk_full_ofs);
      mem_wdata = pk_full_word;
    end else begin
      case (state)
        ST_FETCH: begin
          mem_req  = 1'b1;
          mem_addr = cur + ADDR_W'(fidx);
        end
        ST_FLUSH: begin
          if (pk_part_any) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_base + ADDR_W'(pk_part_ofs);
            mem_wdata = pk_part_word;
          end
        end
        ST_WBLEN: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = cur + ADDR_W'(DESC_LEN_OFS);
          mem_wdata = WORD_W'(pk_count);
        end
        ST_WBST: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = cur;
          mem_wdata = st_word;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fidx       <= '0;
      cur        <= '0;
      buf_base   <= '0;
      nxt        <= '0;
      cap        <= '0;
      err_q      <= '0;
      ring_empty <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (base_load) cur <= base_addr;
          if (start) begin
            state      <= ST_FETCH;
            fidx       <= '0;
            ring_empty <= 1'b0;
          end
        end
        ST_FETCH: state <= ST_WAIT;
        ST_WAIT: begin
          case (fidx)
            2'd0: begin
              if (!mem_rdata[OWN_BIT]) begin
                state      <= ST_IDLE;
                ring_empty <= 1'b1;
              end else begin
                state <= ST_FETCH;
                fidx  <= 2'd1;
              end
            end
            2'd1: begin
              buf_base <= mem_rdata[ADDR_W-1:0];
              state    <= ST_FETCH;
              fidx     <= 2'd2;
            end
            2'd2: begin
              cap   <= mem_rdata[LEN_W-1:0];
              state <= ST_FETCH;
              fidx  <= 2'd3;
            end
            default: begin
              nxt   <= mem_rdata[ADDR_W-1:0];
              state <= ST_RECV;
            end
          endcase
        end
        ST_RECV: begin
          if (beat && rx_last) begin
            err_q <= rx_err;
            state <= ST_FLUSH;
          end
        end
        ST_FLUSH: if (!pk_pend) state <= ST_WBLEN;
        ST_WBLEN: state <= ST_WBST;
        ST_WBST: begin
          frame_done <= 1'b1;
          cur        <= nxt;
          fidx       <= '0;
          state      <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              start,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [1:0]        rx_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              ring_empty,
  output logic              frame_done
);
  localparam int OFS_W = LEN_W - 2;

  logic             beat;
  logic             pk_clear;
  logic             pk_flush_ack;
  logic [LEN_W-1:0] cap;
  logic             pk_pend;
  logic [31:0]      pk_full_word;
  logic [OFS_W-1:0] pk_full_ofs;
  logic             pk_part_any;
  logic [31:0]      pk_part_word;
  logic [OFS_W-1:0] pk_part_ofs;
  logic [LEN_W-1:0] pk_count;
  logic             pk_giant;

  rxr_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_load    (base_load),
    .base_addr    (base_addr),
    .start        (start),
    .rx_valid     (rx_valid),
    .rx_last      (rx_last),
    .rx_err       (rx_err),
    .rx_ready     (rx_ready),
    .beat         (beat),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .busy         (busy),
    .ring_empty   (ring_empty),
    .frame_done   (frame_done),
    .pk_clear     (pk_clear),
    .pk_flush_ack (pk_flush_ack),
    .cap          (cap),
    .pk_pend      (pk_pend),
    .pk_full_word (pk_full_word),
    .pk_full_ofs  (pk_full_ofs),
    .pk_part_any  (pk_part_any),
    .pk_part_word (pk_part_word),
    .pk_part_ofs  (pk_part_ofs),
    .pk_count     (pk_count),
    .pk_giant     (pk_giant)
  );

  rxr_pack #(.LEN_W(LEN_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (pk_clear),
    .beat      (beat),
    .data      (rx_data),
    .cap       (cap),
    .flush_ack (pk_flush_ack),
    .pend      (pk_pend),
    .full_word (pk_full_word),
    .full_ofs  (pk_full_ofs),
    .part_any  (pk_part_any),
    .part_word (pk_part_word),
    .part_ofs  (pk_part_ofs),
    .count     (pk_count),
    .giant     (pk_giant)
  );
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_ready,
  input logic mem_req,
  input logic mem_we,
  input logic busy,
  input logic ring_empty,
  input logic frame_done
);
  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R9: done follows a memory write
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(mem_req && mem_we));

  // R11: stream accepted only while busy
  a_r11_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> busy);

  // R11: no descriptor read while streaming
  a_r11_no_read_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !rx_ready);

  // R3: empty ring means idle
  a_r3_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ring_empty |-> !busy);
endmodule

bind rxr_engine rxr_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_ready   (rx_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .busy       (busy),
  .ring_empty (ring_empty),
  .frame_done (frame_done)
);

// File: tb/tb_rxr_engine.sv
module tb_rxr_engine;
  localparam int AW = 8;
  localparam int LW = 16;
  localparam logic [31:0] OWN = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          base_load = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          start = 1'b0;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [7:0]    rx_data = '0;
  logic          rx_last = 1'b0;
  logic [1:0]    rx_err = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          busy, ring_empty, frame_done;

  logic [31:0]   mem [0:255];
  logic          pk_en = 1'b0;
  logic [7:0]    pk_a = '0;
  logic [31:0]   pk_d = '0;
  int            rd_cnt = 0;
  int            wr_cnt = 0;
  int            checks = 0;
  int            errors = 0;

  always #4 clk = ~clk;

  rxr_engine #(.ADDR_W(AW), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_addr(base_addr),
    .start(start), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .ring_empty(ring_empty), .frame_done(frame_done)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
        rd_cnt <= rd_cnt + 1;
      end
    end else if (pk_en) begin
      mem[pk_a] <= pk_d;
    end
  end

  function automatic logic [7:0] fb(input logic [7:0] seed, input int k);
    return seed + 8'(k * 7);
  endfunction

  function automatic logic [31:0] ew(input logic [7:0] seed, input int k0, input int nv);
    logic [31:0] w = '0;
    for (int i = 0; i < nv; i++) w[8*i +: 8] = fb(seed, k0 + i);
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); pk_en = 1'b1; pk_a = a; pk_d = d;
    @(negedge clk); pk_en = 1'b0;
  endtask

  task automatic desc(input logic [7:0] a, input logic [31:0] st, input logic [7:0] bufa,
                      input int capv, input logic [7:0] nx);
    poke(a, st); poke(a + 8'd1, 32'(bufa)); poke(a + 8'd2, 32'(capv)); poke(a + 8'd3, 32'(nx));
  endtask

  task automatic kick(input logic [7:0] a);
    @(negedge clk); base_load = 1'b1; base_addr = a; start = 1'b1;
    @(negedge clk); base_load = 1'b0; start = 1'b0;
  endtask

  task automatic send(input logic [7:0] seed, input int n, input logic [1:0] err, input bit gaps);
    for (int k = 0; k < n; k++) begin
      bit hs;
      if (gaps && (k % 3 == 1)) begin
        @(negedge clk); rx_valid = 1'b0; rx_data = 8'hEE;
      end
      hs = 1'b0;
      while (!hs) begin
        @(negedge clk);
        rx_valid = 1'b1; rx_data = fb(seed, k); rx_last = (k == n - 1); rx_err = err;
        hs = rx_ready;
      end
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!frame_done && t < 200) begin @(negedge clk); t++; end
    chk(req, 32'(frame_done), 32'd1);
    @(negedge clk);
    chk("R9 done pulse width", 32'(frame_done), 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 ring_empty", 32'(ring_empty), 0);
    chk("R1 frame_done", 32'(frame_done), 0);
    chk("R1 rx_ready", 32'(rx_ready), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_empty;
    int w0, r0;
    desc(8'h10, 32'h0000_1234, 8'h90, 64, 8'h10);
    w0 = wr_cnt;
    kick(8'h10);
    repeat (6) @(negedge clk);
    chk("R3 ring_empty set", 32'(ring_empty), 1);
    chk("R3 idle", 32'(busy), 0);
    chk("R3 no writes", 32'(wr_cnt - w0), 0);
    chk("R3 status kept", mem[8'h10], 32'h0000_1234);
    r0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk("R3 no polling", 32'(rd_cnt - r0), 0);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 restart reads status only", 32'(rd_cnt - r0), 1);
    chk("R2 restart same address empty", 32'(ring_empty), 1);
  endtask

  task automatic t_ring;
    poke(8'h43, 32'hA5A5_A5A5);
    poke(8'h60, 32'h0000_0000);
    desc(8'h20, OWN, 8'h40, 64, 8'h24);
    desc(8'h24, OWN | 32'h0000_0F00, 8'h80, 64, 8'h20);
    kick(8'h20);
    repeat (12) @(negedge clk);
    chk("R11 ready with open buffer", 32'(rx_ready), 1);
    // R12: these commands arrive while busy
    @(negedge clk); base_load = 1'b1; base_addr = 8'h60; start = 1'b1;
    @(negedge clk); base_load = 1'b0; start = 1'b0;
    send(8'h11, 10, 2'b00, 1'b0);
    wait_done("R9 done after frame 1");
    chk("R4 word0", mem[8'h40], ew(8'h11, 0, 4));
    chk("R4 word1", mem[8'h41], ew(8'h11, 4, 4));
    chk("R5 partial word", mem[8'h42], ew(8'h11, 8, 2));
    chk("R5 next word untouched", mem[8'h43], 32'hA5A5_A5A5);
    chk("R6 length", mem[8'h22], 32'd10);
    chk("R7 status clean", mem[8'h20], 32'd0);
    chk("R12 base_load ignored", mem[8'h60], 32'd0);
    send(8'h52, 8, 2'b10, 1'b1);
    wait_done("R10 done after frame 2");
    chk("R11 gapped word0", mem[8'h80], ew(8'h52, 0, 4));
    chk("R11 gapped word1", mem[8'h81], ew(8'h52, 4, 4));
    chk("R6 length 2", mem[8'h26], 32'd8);
    chk("R7 error bits", mem[8'h24], 32'h0000_0004);
    repeat (8) @(negedge clk);
    chk("R10 wrap stops empty", 32'(ring_empty), 1);
    chk("R10 next pointer kept", mem[8'h27], 32'h20);
  endtask

  task automatic t_giant;
    poke(8'hC0, 32'hDEAD_BEEF); poke(8'hC1, 32'hDEAD_BEEF); poke(8'hC2, 32'hDEAD_BEEF);
    desc(8'h30, OWN, 8'hC0, 6, 8'h30);
    kick(8'h30);
    send(8'h33, 11, 2'b01, 1'b0);
    wait_done("R8 done after giant");
    chk("R8 word0", mem[8'hC0], ew(8'h33, 0, 4));
    chk("R8 word1 capped", mem[8'hC1], ew(8'h33, 4, 2));
    chk("R8 past capacity", mem[8'hC2], 32'hDEAD_BEEF);
    chk("R8 length = capacity", mem[8'h32], 32'd6);
    chk("R8 giant status", mem[8'h30], 32'h0000_2002);
    repeat (8) @(negedge clk);
    chk("R10 self ring empty", 32'(ring_empty), 1);
    chk("R11 ready low when idle", 32'(rx_ready), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    t_reset();
    t_empty();
    t_ring();
    t_giant();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule